// File: doc/BRIEF.md
# Reset Cause Status Register

This block holds a 32-bit reset status and control word, of which only the five most significant bits carry state. The remaining bits always read as zero. Each reset that the system goes through is signalled on a one-cycle event input. A saturating counter records how many of these events have happened. The first event after the counter was last zero loads the word with the power-on flag alone. Later events leave the word as it is.

Software reaches the word through a simple read/write port. A slot select picks one of two 32-bit words in an 8-byte slot. The upper word holds the register. The lower word reads as zero, and writes to it are ignored.

Bit 31 (power-on), bit 28 (button power-on) and bit 27 (button external reset) are cleared by writing 1. Bit 30 (software power-on) and bit 29 (software external reset) are set by writing 1. A write carrying bit 30 or bit 29 raises a one-cycle system reset request. A write carrying bit 30 also clears the event counter, so the next event reports a power-on again.

Top module: `rst_cause_reg`

## Requirements
- R1: After the block's own reset (rstN low), the upper word reads 0x00000000 and sysResetReq is low.
- R2: Only bits 31:27 hold state. Bits 26:0 always read 0, and write data in bits 26:0 has no effect.
- R3: Bits 31, 28 and 27 are write-one-to-clear: a written 1 clears the bit, and a written 0 leaves it unchanged.
- R4: Bits 30 and 29 are write-one-to-set: a written 1 sets the bit, and a written 0 leaves it unchanged.
- R5: With wordSel low (the lower word of the slot), rdData is 0 and writes change neither the register nor sysResetReq.
- R6: A write to the upper word with bit 30 or bit 29 set drives sysResetReq high for exactly the one cycle that follows the write's clock edge. Other writes leave it low.
- R7: A resetEvent that finds the event counter at zero loads the register with 0x80000000, which clears every other bit.
- R8: A resetEvent that finds the counter non-zero leaves the register unchanged.
- R9: A write with bit 30 set clears the event counter, so the next resetEvent behaves as in R7. A write with only bit 29 set leaves the counter as it is.
- R10: The counter stops at 2^CNT_W-1 and does not wrap, so any number of further events never reloads the power-on flag.
- R11: A write in the same cycle as a resetEvent is dropped. The register follows R7/R8 only, and no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the block itself |
| resetEvent | input | 1 | One-cycle indication that a system reset took place |
| wordSel | input | 1 | Word select in the 8-byte slot: 1 = upper (+4) word holding the register, 0 = lower word |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for the selected word |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with CNT_W = 2, so the counter saturates after three events. This puts the non-wrapping behaviour within reach of a short event sequence: a wrapping counter would reload the power-on flag on the fifth event. All 32 combinations of the five meaningful write bits are swept twice, once with the unused low bits clear and once with them set. Each step is compared against an arithmetic model of the clear and set masks, the counter and the request pulse.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int STAT_W = 5;
  // field bit 4..0 map to register bits 31..27
  localparam logic [STAT_W-1:0] W1C_BITS = 5'b10011;
  localparam logic [STAT_W-1:0] W1S_BITS = 5'b01100;
  localparam logic [STAT_W-1:0] POR_ONLY = 5'b10000;
  localparam int SW_POR_IDX = 3;
  localparam int SW_XIR_IDX = 2;

  typedef struct packed {
    logic              loadPor;
    logic              applyWr;
    logic [STAT_W-1:0] clrBits;
    logic [STAT_W-1:0] setBits;
  } rc_strobe_t;
endpackage

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetEvent,
  input  logic              wordSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output rc_strobe_t        strobe,
  output logic              sysResetReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [STAT_W-1:0] field;
  logic              wrHit;
  logic              reqNext;
  logic [CNT_W-1:0]  evtCnt;
  logic              unusedLowBits;

  assign field         = wrData[DATA_W-1 -: STAT_W];
  assign unusedLowBits = ^wrData[DATA_W-STAT_W-1:0];
  assign wrHit         = wrEn && wordSel && !resetEvent;
  assign reqNext       = wrHit && (field[SW_POR_IDX] || field[SW_XIR_IDX]);

  always_comb begin
    strobe.loadPor = resetEvent && (evtCnt == '0);
    strobe.applyWr = wrHit;
    strobe.clrBits = field & W1C_BITS;
    strobe.setBits = field & W1S_BITS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtCnt      <= '0;
      sysResetReq <= 1'b0;
    end else begin
      sysResetReq <= reqNext;
      if (resetEvent) begin
        if (evtCnt != CNT_MAX) evtCnt <= evtCnt + 1'b1;
      end else if (wrHit && field[SW_POR_IDX]) begin
        evtCnt <= '0;
      end
    end
  end

  // R6: a request pulse is always caused by a qualifying write one edge earlier
  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(wrEn && wordSel && !resetEvent &&
                          (wrData[DATA_W-1-(STAT_W-1-SW_POR_IDX)] ||
                           wrData[DATA_W-1-(STAT_W-1-SW_XIR_IDX)])));

  // R10: counter holds at its ceiling
  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resetEvent && evtCnt == CNT_MAX) |=> evtCnt == CNT_MAX);

  // R9: software power-on write re-arms the counter
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordSel && !resetEvent && field[SW_POR_IDX]) |=> evtCnt == '0);
endmodule

// File: rtl/rst_cause_dp.sv
module rst_cause_dp
  import rst_cause_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rc_strobe_t        strobe,
  input  logic              wordSel,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] statQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else if (strobe.loadPor) begin
      statQ <= POR_ONLY;
    end else if (strobe.applyWr) begin
      statQ <= (statQ & ~strobe.clrBits) | strobe.setBits;
    end
  end

  assign rdData = wordSel ? {statQ, {PAD_W{1'b0}}} : '0;

  // R7: a first event leaves only the power-on flag
  p_por_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPor |=> statQ == POR_ONLY);

  // R8: without a load or a write the state holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadPor && !strobe.applyWr) |=> $stable(statQ));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetEvent,
  input  logic              wordSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sysResetReq
);
  rc_strobe_t strobe;

  rst_cause_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resetEvent (resetEvent),
    .wordSel    (wordSel),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .strobe     (strobe),
    .sysResetReq(sysResetReq)
  );

  rst_cause_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordSel(wordSel),
    .rdData (rdData)
  );
endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int CNT_W = 2;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetEvent = 1'b0;
  logic        wordSel = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sysResetReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [4:0] mStat = '0;
  int         mCnt  = 0;

  rst_cause_reg #(.DATA_W(32), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .resetEvent(resetEvent), .wordSel(wordSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .sysResetReq(sysResetReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readCheck(input string req);
    wordSel = 1'b1; #1;
    check(req, rdData, {mStat, 27'd0});
  endtask

  // one clock edge with the given stimulus; returns at the next falling edge
  task automatic cycle(input logic sel, input logic we, input logic [31:0] d, input logic evt);
    @(negedge clk);
    wordSel = sel; wrEn = we; wrData = d; resetEvent = evt;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; resetEvent = 1'b0; wrData = '0;
  endtask

  function automatic logic modelWrite(input logic [31:0] d);
    logic [4:0] f;
    f = d[31:27];
    mStat = (mStat & ~(f & 5'b10011)) | (f & 5'b01100);
    if (f[3]) mCnt = 0;
    return f[3] | f[2];
  endfunction

  function automatic void modelEvent();
    if (mCnt == 0) mStat = 5'b10000;
    if (mCnt != CMAX) mCnt++;
  endfunction

  task automatic doWrite(input logic [31:0] d, input string req);
    logic p;
    p = modelWrite(d);
    cycle(1'b1, 1'b1, d, 1'b0);
    check({req, "/R6 pulse"}, {31'd0, sysResetReq}, {31'd0, p});
    @(negedge clk);
    check("R6 pulse width", {31'd0, sysResetReq}, 32'd0);
    readCheck(req);
  endtask

  task automatic doEvent(input string req);
    modelEvent();
    cycle(1'b1, 1'b0, '0, 1'b1);
    check({req, " no pulse"}, {31'd0, sysResetReq}, 32'd0);
    readCheck(req);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    readCheck("R1");
    check("R1 pulse", {31'd0, sysResetReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck("R1");
    wordSel = 1'b0; #1;
    check("R5 even read", rdData, 32'd0);

    // R7 first event loads power-on flag
    doEvent("R7");
    // R4 set software bits, then R8 later event keeps them
    doWrite(32'h6000_0000, "R4");
    doEvent("R8");

    // R2 R3 R4 R6 sweep of all field values, low bits clear and set
    for (int pass = 0; pass < 2; pass++) begin
      for (int f = 0; f < 32; f++) begin
        logic [31:0] d;
        d = {f[4:0], (pass == 1) ? 27'h7FF_FFFF : 27'd0};
        doWrite(d, (pass == 1) ? "R2" : "R3/R4");
        if (f % 4 == 3) doEvent("R7/R8");
      end
    end

    // R5 lower word writes are ignored
    doWrite(32'h6000_0000, "R4");
    cycle(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
    check("R5 no pulse", {31'd0, sysResetReq}, 32'd0);
    check("R5 even read", rdData, 32'd0);
    readCheck("R5");

    // R9 bit 29 alone keeps counter, bit 30 re-arms it
    doEvent("R8");
    doWrite(32'h2000_0000, "R9");
    doEvent("R9");
    doWrite(32'h4000_0000, "R9");
    doEvent("R9");
    check("R9 por flag", rdData, 32'h8000_0000);

    // R10 saturation: many events, clear flag, still no reload
    for (int i = 0; i < 7; i++) begin
      doEvent("R10");
      doWrite(32'h9800_0000, "R10");
    end
    check("R10 no reload", rdData, {mStat, 27'd0});

    // R11 write with event in the same cycle is dropped
    doWrite(32'h4000_0000, "R9");
    modelEvent();
    cycle(1'b1, 1'b1, 32'hF800_0000, 1'b1);
    check("R11 no pulse", {31'd0, sysResetReq}, 32'd0);
    readCheck("R11");
    modelEvent();
    cycle(1'b1, 1'b1, 32'h9800_0000, 1'b1);
    check("R11 no pulse", {31'd0, sysResetReq}, 32'd0);
    readCheck("R11");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule